// File: doc/BRIEF.md
# NAND Byte-Stream Scrambler

This block sits in the data path between a flash controller's page buffer and the NAND device. It whitens the byte stream so that long runs of equal bits never reach the array. A 15-bit linear feedback shift register produces an 8-bit mask for each byte, and the byte is XORed with that mask. The register then moves eight steps ahead. Scrambling and descrambling are the same operation, so one instance serves both writes and reads.

A neighbouring block works out which seed suits the current page and column. It loads that seed through a 32-bit control word and the load strobe. A transfer is split into chunks, and the register must be seeded again at each chunk boundary. When a full chunk has passed without a new seed, the block stalls the stream until one arrives. With enable low, bytes pass through unchanged. When the controller reads a page it has found to be erased, the bypass flag forces every output byte to all-ones.

Top module: `byte_scrambler`

## Requirements
- R1: After reset the register holds RESET_SEED (default 15'h4A80) and the chunk count is zero, so the first enabled byte is XORed with 8'h80.
- R2: A load strobe copies control-word bits [30:16] into the register and restarts the chunk count. Bit 31 and bits [15:0] have no effect on the register.
- R3: The mask for a byte is bits [7:0] of the register before that byte's steps. One step shifts the register right by one and places bit0 XOR bit1 into bit 14. Eight steps are taken per transferred byte.
- R4: The register advances only on a transfer (in_valid and in_ready both high). Under back-pressure it keeps its value.
- R5: While scr_en is low, out_data equals in_data, and neither the register nor the chunk count changes.
- R6: When a load and a transfer happen in the same cycle, the load wins. The byte uses the newly loaded seed, and the register then holds that seed advanced by eight steps.
- R7: With scr_en, erased and dir_rd all high, out_data is 8'hFF and the register still advances. With dir_rd low, erased has no effect.
- R8: After CHUNK_LEN enabled transfers with no load, need_seed is high and in_ready and out_valid are low until a load arrives.
- R9: When the stream is not stalled, out_valid follows in_valid and in_ready follows out_ready in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scr_en | input | 1 | Enables the mask; low means pass-through |
| dir_rd | input | 1 | High for a read from the NAND, low for a write |
| erased | input | 1 | Current page is known to be erased |
| cfg_load | input | 1 | Load strobe for the seed field |
| cfg_word | input | 32 | Control word; seed in bits [30:16] |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Block accepts the input byte |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Scrambled or descrambled byte |
| out_ready | input | 1 | Sink accepts the output byte |
| need_seed | output | 1 | Chunk exhausted; a new seed is required |

## Verification
The bench builds the block with CHUNK_LEN set to 8 and keeps the other parameters at their defaults. The short chunk brings the stall at the chunk boundary within a few cycles, and the vector table can still run several multi-byte bursts from different seeds. The default 15-bit register and the bit-16 seed field stay as they are, so the mask sequence and the masking of bit 31 are checked exactly as the neighbouring block would use them.

// File: rtl/byte_scrambler.sv
module byte_scrambler #(
  parameter int LFSR_W = 15,
  parameter int DATA_W = 8,
  parameter int CFG_W = 32,
  parameter int SEED_LSB = 16,
  parameter int CHUNK_LEN = 1024,
  parameter logic [14:0] RESET_SEED = 15'h4A80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scr_en,
  input  logic              dir_rd,
  input  logic              erased,
  input  logic              cfg_load,
  input  logic [CFG_W-1:0]  cfg_word,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready,
  output logic              need_seed
);
  localparam int CNT_W = $clog2(CHUNK_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(CHUNK_LEN);

  logic [LFSR_W-1:0] state;
  logic [LFSR_W-1:0] cur;
  logic [LFSR_W-1:0] stepped;
  logic [CNT_W-1:0]  cnt;
  logic              fire;
  logic              adv;

  assign cur       = cfg_load ? cfg_word[SEED_LSB +: LFSR_W] : state;
  assign need_seed = scr_en && (cnt == CNT_FULL) && !cfg_load;
  assign in_ready  = out_ready && !need_seed;
  assign out_valid = in_valid && !need_seed;
  assign fire      = in_valid && in_ready;
  assign adv       = fire && scr_en;

  always_comb begin
    stepped = cur;
    for (int i = 0; i < DATA_W; i++)
      stepped = {stepped[0] ^ stepped[1], stepped[LFSR_W-1:1]};
  end

  always_comb begin
    if (!scr_en)
      out_data = in_data;
    else if (erased && dir_rd)
      out_data = '1;
    else
      out_data = in_data ^ cur[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= RESET_SEED[LFSR_W-1:0];
      cnt   <= '0;
    end else begin
      if (adv)
        state <= stepped;
      else if (cfg_load)
        state <= cur;
      if (cfg_load)
        cnt <= adv ? CNT_W'(1) : '0;
      else if (adv)
        cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/byte_scrambler_sva.sv
module byte_scrambler_sva #(
  parameter int LFSR_W = 15,
  parameter int DATA_W = 8,
  parameter int CFG_W = 32,
  parameter int SEED_LSB = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scr_en,
  input logic              dir_rd,
  input logic              erased,
  input logic              cfg_load,
  input logic [CFG_W-1:0]  cfg_word,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_data,
  input logic              in_ready,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              out_ready,
  input logic              need_seed,
  input logic [LFSR_W-1:0] state
);
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!scr_en && out_valid) |-> out_data == in_data); // R5
  AST_ERASED_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (scr_en && erased && dir_rd && out_valid) |-> out_data == '1); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!(in_valid && in_ready) && !cfg_load) |=> $stable(state)); // R4
  AST_CHUNK_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    need_seed |-> (!in_ready && !out_valid)); // R8
  AST_SEED_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_load && !(in_valid && in_ready && scr_en)) |=> state == $past(cfg_word[SEED_LSB +: LFSR_W])); // R2
  AST_READY_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !need_seed |-> (in_ready == out_ready && out_valid == in_valid)); // R9
endmodule

bind byte_scrambler byte_scrambler_sva #(
  .LFSR_W(LFSR_W), .DATA_W(DATA_W), .CFG_W(CFG_W), .SEED_LSB(SEED_LSB)
) u_sva (
  .clk(clk), .rst_n(rst_n), .scr_en(scr_en), .dir_rd(dir_rd), .erased(erased),
  .cfg_load(cfg_load), .cfg_word(cfg_word), .in_valid(in_valid), .in_data(in_data),
  .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
  .out_ready(out_ready), .need_seed(need_seed), .state(state)
);

// File: tb/test_byte_scrambler.sv
module test_byte_scrambler;
  localparam int CHUNK = 8;
  localparam int NVEC = 5;
  // each entry: {seed[14:0], first byte[7:0], length[7:0]}
  localparam logic [30:0] VEC [NVEC] = '{
    {15'h4A80, 8'h00, 8'd4},
    {15'h0001, 8'h5A, 8'd8},
    {15'h7FFF, 8'hFF, 8'd3},
    {15'h1234, 8'h10, 8'd6},
    {15'h6C3B, 8'hA5, 8'd2}
  };

  logic clk = 0, rst_n = 0;
  logic scr_en = 0, dir_rd = 0, erased = 0, cfg_load = 0;
  logic [31:0] cfg_word = '0;
  logic in_valid = 0, out_ready = 1;
  logic [7:0] in_data = '0;
  logic in_ready, out_valid, need_seed;
  logic [7:0] out_data;
  int errors = 0, checks = 0;
  logic [14:0] model;

  always #10 clk = ~clk;

  byte_scrambler #(.CHUNK_LEN(CHUNK)) i_byte_scrambler (
    .clk(clk), .rst_n(rst_n), .scr_en(scr_en), .dir_rd(dir_rd), .erased(erased),
    .cfg_load(cfg_load), .cfg_word(cfg_word), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .need_seed(need_seed)
  );

  function automatic logic [14:0] adv8(input logic [14:0] s);
    for (int i = 0; i < 8; i++) s = {s[0] ^ s[1], s[14:1]};
    return s;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input logic [31:0] w);
    @(negedge clk); cfg_load = 1; cfg_word = w;
    @(posedge clk); #1 cfg_load = 0;
  endtask

  // transfer one byte; check output before the edge
  task automatic xfer(input string req, input logic [7:0] d, input logic [7:0] exp);
    @(negedge clk); in_valid = 1; in_data = d; out_ready = 1;
    #5;
    chk(req, {out_valid, out_data}, {1'b1, exp});
    @(posedge clk); #1 in_valid = 0;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 idle", {out_valid, need_seed, in_ready}, 3'b001);
    scr_en = 1;
    model = 15'h4A80;
    xfer("R1 first mask", 8'h00, 8'h80);
    model = adv8(model);
    xfer("R3 second byte", 8'h3C, 8'h3C ^ model[7:0]);

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      load({1'b0, VEC[v][30:16], 16'h0000});
      model = VEC[v][30:16];
      for (int b = 0; b < int'(VEC[v][7:0]); b++) begin
        logic [7:0] d;
        d = VEC[v][15:8] + 8'(b * 37);
        xfer("R3 table", d, d ^ model[7:0]);
        model = adv8(model);
      end
    end

    // R2: bit 31 and low half ignored
    load({1'b1, 15'h2B6D, 16'hFFFF});
    model = 15'h2B6D;
    xfer("R2 seed field", 8'h00, model[7:0]);
    model = adv8(model);

    // R4: back-pressure holds state
    @(negedge clk); in_valid = 1; in_data = 8'h11; out_ready = 0;
    #5 chk("R4 stalled ready", {in_ready, out_valid}, 2'b01);
    @(posedge clk); @(negedge clk); in_valid = 0; out_ready = 1;
    xfer("R4 held mask", 8'h11, 8'h11 ^ model[7:0]);
    model = adv8(model);

    // R5: disabled pass-through and frozen state
    scr_en = 0;
    xfer("R5 pass a", 8'hC3, 8'hC3);
    xfer("R5 pass b", 8'h7E, 8'h7E);
    scr_en = 1;
    xfer("R5 resumed mask", 8'h00, model[7:0]);
    model = adv8(model);

    // R6: load with transfer in the same cycle
    @(negedge clk); cfg_load = 1; cfg_word = {1'b0, 15'h5555, 16'h0}; in_valid = 1; in_data = 8'hF0;
    #5 chk("R6 new seed used", out_data, 8'hF0 ^ 8'h55);
    @(posedge clk); #1 cfg_load = 0; in_valid = 0;
    model = adv8(15'h5555);
    xfer("R6 advanced after", 8'h00, model[7:0]);
    model = adv8(model);

    // R7: erased read forces ones, state advances; write ignores flag
    erased = 1; dir_rd = 1;
    xfer("R7 erased read", 8'h12, 8'hFF);
    model = adv8(model);
    dir_rd = 0;
    xfer("R7 erased write", 8'h12, 8'h12 ^ model[7:0]);
    model = adv8(model);
    erased = 0;

    // R8: chunk boundary stall
    load({1'b0, 15'h0F0F, 16'h0});
    model = 15'h0F0F;
    for (int b = 0; b < CHUNK; b++) begin
      xfer("R8 fill chunk", 8'(b), 8'(b) ^ model[7:0]);
      model = adv8(model);
    end
    @(negedge clk); in_valid = 1; in_data = 8'h00;
    #5 chk("R8 stall", {need_seed, in_ready, out_valid}, 3'b100);
    @(posedge clk); #1 in_valid = 0;
    load({1'b0, 15'h0F0F, 16'h0});
    #1 chk("R8 released", {need_seed, in_ready}, 2'b01);
    model = 15'h0F0F;
    xfer("R9 after reseed", 8'h00, model[7:0]);

    // R9: out_valid tracks in_valid, in_ready tracks out_ready
    @(negedge clk); in_valid = 0; out_ready = 0;
    #5 chk("R9 idle", {out_valid, in_ready}, 2'b00);
    out_ready = 1;

    // R1: reset again restores seed
    @(negedge clk); rst_n = 0; @(posedge clk); #1 rst_n = 1;
    xfer("R1 reset seed", 8'hFF, 8'hFF ^ 8'h80);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule